// File: doc/BRIEF.md
# SIMD/FP Power Domain Sequencer

This block switches a separately supplied SIMD and floating-point unit on and off inside a processor cluster. It drives three controls for that domain: an active-low isolation clamp, a power-switch enable and a domain reset. It also raises a unit-available flag that the instruction decoder uses to trap SIMD and floating-point instructions as undefined while the unit is off. The inputs are single-cycle power-up and power-down requests, a core-in-reset level, a cold powerup-reset level, a software acknowledge that unit access has been disabled, and the power-good feedback from the switch.

A power-down follows one of two orderings. While the core runs, the sequencer drops unit-available and then waits for software to confirm that access is disabled. Only then does it assert the clamp, and one cycle later it opens the switch. While the core is held in reset, there is no software to answer, so the clamp goes on straight away and the switch follows. A cold powerup reset keeps the domain off while the other domains come up. The sequencer remembers one requested target (on or off). A request that arrives during a transition waits until that transition has finished. If power-good does not arrive within a bounded time, the attempt is abandoned and a sticky error is raised.

Top module: `simd_pwr_seq`

## Requirements
- R1: After a synchronous reset the outputs are iso_n=0, psw_en=0, dom_rst=1, unit_avail=0 and pg_timeout_err=0.
- R2: Power-up ordering. The switch enable rises first. When power-good is already high at that point, iso_n rises exactly rst_hold+2 cycles after psw_en rises. For those rst_hold+2 cycles psw_en=1 and iso_n=0. For the next single cycle iso_n=1, dom_rst=1 and unit_avail=0. After that dom_rst=0 and unit_avail=1.
- R3: iso_n is never 1 while psw_en is 0. iso_n rises only after a cycle in which pwr_good was 1.
- R4: Running-core power-down (core_in_reset=0). After a down request, unit_avail falls while iso_n and psw_en stay 1. They stay 1 as long as sw_unit_off is 0. One cycle after sw_unit_off is seen, iso_n=0. One cycle after that, psw_en=0.
- R5: In-reset power-down (core_in_reset=1). iso_n falls without waiting for sw_unit_off, and psw_en falls one cycle after iso_n.
- R6: While cold_por=1 the switch is never enabled. An up request made during cold_por takes effect once cold_por returns to 0. Raising cold_por while the unit is on performs the in-reset power-down.
- R7: A down request made while a power-up is in progress is held. The power-up completes (unit_avail reaches 1) and the domain then powers down. Up requests made during a power-down are held in the same way.
- R8: When up_req and dn_req are high in the same cycle, the down request wins.
- R9: iso_n and psw_en never change in the same cycle.
- R10: If pwr_good stays low, psw_en stays high for exactly PG_TIMEOUT cycles and then falls. The clamp stays asserted throughout. pg_timeout_err rises and stays 1 until reset, and the pending up request is dropped.
- R11: unit_avail is 1 only while the clamp is released and the switch is on. It is 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| up_req | input | 1 | Single-cycle request to power the unit on |
| dn_req | input | 1 | Single-cycle request to power the unit off |
| core_in_reset | input | 1 | High while the core is held in reset |
| cold_por | input | 1 | High during a cold powerup reset |
| sw_unit_off | input | 1 | Software acknowledge that unit access is disabled |
| pwr_good | input | 1 | Domain supply is stable |
| rst_hold | input | HOLD_W | Extra cycles of domain reset after power-good |
| iso_n | output | 1 | Isolation clamp, active low |
| psw_en | output | 1 | Power-switch enable |
| dom_rst | output | 1 | Domain reset, active high |
| unit_avail | output | 1 | Unit usable; low makes SIMD/FP instructions trap |
| pg_timeout_err | output | 1 | Sticky power-good timeout flag |

## Verification
The two events that can coincide are a power-down request and the power-up sequence. A down request can arrive in the cycle the switch first sees power-good, and up and down requests can also arrive together. The bench issues a down pulse while the switch is waiting for a slow power-good. It then checks that the unit still reaches unit_avail=1 before going back to off. It also pulses both requests in one cycle and confirms that the switch never turns on. Throughout every scenario, a monitor compares successive samples of iso_n and psw_en and flags any cycle in which both changed.

// File: rtl/simd_pwr_pkg.sv
package simd_pwr_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_UP_PWR,
        S_UP_HOLD,
        S_UP_REL,
        S_ON,
        S_DN_DRAIN,
        S_DN_ISO
    } seq_state_e;

    typedef struct packed {
        logic iso_n;
        logic psw_en;
        logic dom_rst;
        logic avail;
    } dom_ctl_t;

    typedef struct packed {
        seq_state_e st;
        logic       err;
    } seq_reg_t;

endpackage

// File: rtl/simd_pwr_req_latch.sv
module simd_pwr_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic up,
    input  logic dn,
    input  logic clr,
    output logic target
);
    logic target_d, target_q;

    always_comb begin
        target_d = target_q;
        if (up)
            target_d = 1'b1;
        if (dn || clr)
            target_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            target_q <= 1'b0;
        else
            target_q <= target_d;
    end

    assign target = target_q;
endmodule

// File: rtl/simd_pwr_timer.sv
module simd_pwr_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/simd_pwr_out_dec.sv
module simd_pwr_out_dec
    import simd_pwr_pkg::*;
(
    input  seq_state_e st,
    output dom_ctl_t   ctl
);
    always_comb begin
        ctl = '{iso_n: 1'b0, psw_en: 1'b0, dom_rst: 1'b1, avail: 1'b0};
        case (st)
            S_UP_PWR, S_UP_HOLD: ctl.psw_en = 1'b1;
            S_UP_REL: begin
                ctl.psw_en = 1'b1;
                ctl.iso_n  = 1'b1;
            end
            S_ON: ctl = '{iso_n: 1'b1, psw_en: 1'b1, dom_rst: 1'b0, avail: 1'b1};
            S_DN_DRAIN: ctl = '{iso_n: 1'b1, psw_en: 1'b1, dom_rst: 1'b0, avail: 1'b0};
            S_DN_ISO: ctl.psw_en = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/simd_pwr_seq.sv
module simd_pwr_seq
    import simd_pwr_pkg::*;
#(
    parameter int HOLD_W     = 8,
    parameter int PG_TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_req,
    input  logic              dn_req,
    input  logic              core_in_reset,
    input  logic              cold_por,
    input  logic              sw_unit_off,
    input  logic              pwr_good,
    input  logic [HOLD_W-1:0] rst_hold,
    output logic              iso_n,
    output logic              psw_en,
    output logic              dom_rst,
    output logic              unit_avail,
    output logic              pg_timeout_err
);
    localparam int PG_W  = $clog2(PG_TIMEOUT + 1);
    localparam int TMR_W = (HOLD_W > PG_W) ? HOLD_W : PG_W;
    localparam logic [TMR_W-1:0] PG_LOAD = TMR_W'(PG_TIMEOUT - 1);

    seq_reg_t         r_d, r_q;
    logic             target, tgt_clr, tmr_zero, tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             go_down, rst_path;
    dom_ctl_t         ctl;

    simd_pwr_req_latch u_req (
        .clk    (clk),
        .rst    (rst),
        .up     (up_req),
        .dn     (dn_req),
        .clr    (tgt_clr),
        .target (target)
    );

    simd_pwr_timer #(.W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        r_d      = r_q;
        tgt_clr  = 1'b0;
        go_down  = !target || cold_por;
        rst_path = core_in_reset || cold_por;
        case (r_q.st)
            S_OFF:
                if (target && !cold_por)
                    r_d.st = S_UP_PWR;
            S_UP_PWR:
                if (cold_por)
                    r_d.st = S_OFF;
                else if (pwr_good)
                    r_d.st = S_UP_HOLD;
                else if (tmr_zero) begin
                    r_d.st  = S_OFF;
                    r_d.err = 1'b1;
                    tgt_clr = 1'b1;
                end
            S_UP_HOLD:
                if (cold_por)
                    r_d.st = S_OFF;
                else if (!pwr_good)
                    r_d.st = S_UP_PWR;
                else if (tmr_zero)
                    r_d.st = S_UP_REL;
            S_UP_REL:
                r_d.st = S_ON;
            S_ON:
                if (go_down)
                    r_d.st = rst_path ? S_DN_ISO : S_DN_DRAIN;
            S_DN_DRAIN:
                if (sw_unit_off || rst_path)
                    r_d.st = S_DN_ISO;
            S_DN_ISO:
                r_d.st = S_OFF;
            default:
                r_d.st = S_OFF;
        endcase
        tmr_load = (r_d.st != r_q.st);
        tmr_val  = (r_d.st == S_UP_PWR) ? PG_LOAD : TMR_W'(rst_hold);
    end

    always_ff @(posedge clk) begin
        if (rst)
            r_q <= '{st: S_OFF, err: 1'b0};
        else
            r_q <= r_d;
    end

    simd_pwr_out_dec u_dec (
        .st  (r_q.st),
        .ctl (ctl)
    );

    assign iso_n          = ctl.iso_n;
    assign psw_en         = ctl.psw_en;
    assign dom_rst        = ctl.dom_rst;
    assign unit_avail     = ctl.avail;
    assign pg_timeout_err = r_q.err;
endmodule

// File: rtl/simd_pwr_seq_chk.sv
module simd_pwr_seq_chk (
    input logic clk,
    input logic rst,
    input logic core_in_reset,
    input logic cold_por,
    input logic sw_unit_off,
    input logic pwr_good,
    input logic iso_n,
    input logic psw_en,
    input logic unit_avail,
    input logic pg_timeout_err
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    // R3
    clamp_needs_power_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        iso_n |-> psw_en);

    // R3
    clamp_release_after_pg_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(iso_n) |-> $past(pwr_good));

    // R9
    no_same_cycle_edges_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !(!$stable(iso_n) && !$stable(psw_en)));

    // R4
    clamp_before_cut_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $fell(psw_en) |-> !$past(iso_n));

    // R4
    clamp_needs_ack_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $fell(iso_n) |-> $past(sw_unit_off || core_in_reset || cold_por));

    // R6
    cold_holds_clamp_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (cold_por && !iso_n) |=> !iso_n);

    // R6
    no_switch_on_in_cold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(psw_en) |-> !$past(cold_por));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        pg_timeout_err |=> pg_timeout_err);

    // R11
    avail_after_release_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        unit_avail |-> $past(iso_n));
endmodule

bind simd_pwr_seq simd_pwr_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .core_in_reset  (core_in_reset),
    .cold_por       (cold_por),
    .sw_unit_off    (sw_unit_off),
    .pwr_good       (pwr_good),
    .iso_n          (iso_n),
    .psw_en         (psw_en),
    .unit_avail     (unit_avail),
    .pg_timeout_err (pg_timeout_err)
);

// File: tb/tb_simd_pwr_seq.sv
`timescale 1ns/1ps
module tb_simd_pwr_seq;
    localparam int HOLD_W = 8;
    localparam int PG_TO  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_req = 1'b0, dn_req = 1'b0, core_in_reset = 1'b0, cold_por = 1'b0, sw_unit_off = 1'b0;
    logic pwr_good;
    logic [HOLD_W-1:0] rst_hold = '0;
    logic iso_n, psw_en, dom_rst, unit_avail, pg_timeout_err;

    logic       pg_ok  = 1'b1;
    logic [3:0] pg_dly = 4'd0;
    logic [3:0] pg_cnt;

    int checks = 0, errors = 0;
    int viol_edge = 0, viol_iso = 0, viol_avail = 0;
    logic prev_iso, prev_psw, have_prev = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    simd_pwr_seq #(.HOLD_W(HOLD_W), .PG_TIMEOUT(PG_TO)) dut (
        .clk(clk), .rst(rst), .up_req(up_req), .dn_req(dn_req),
        .core_in_reset(core_in_reset), .cold_por(cold_por), .sw_unit_off(sw_unit_off),
        .pwr_good(pwr_good), .rst_hold(rst_hold), .iso_n(iso_n), .psw_en(psw_en),
        .dom_rst(dom_rst), .unit_avail(unit_avail), .pg_timeout_err(pg_timeout_err)
    );

    // simple supply model: power-good follows the switch after pg_dly cycles
    always_ff @(posedge clk) begin
        if (!psw_en)
            pg_cnt <= '0;
        else if (pg_cnt != 4'hF)
            pg_cnt <= pg_cnt + 1'b1;
    end
    assign pwr_good = psw_en && pg_ok && (pg_cnt >= pg_dly);

    // continuous monitors for R3, R9, R11
    always @(negedge clk) begin
        if (!rst) begin
            if (have_prev && (iso_n != prev_iso) && (psw_en != prev_psw)) viol_edge++;
            if (iso_n && !psw_en) viol_iso++;
            if (unit_avail && !(iso_n && psw_en)) viol_avail++;
            have_prev = 1'b1;
        end else
            have_prev = 1'b0;
        prev_iso = iso_n;
        prev_psw = psw_en;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse(input bit u, input bit d);
        @(negedge clk);
        up_req = u; dn_req = d;
        @(negedge clk);
        up_req = 1'b0; dn_req = 1'b0;
    endtask

    task automatic wait_avail(output bit got);
        got = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (unit_avail) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk(iso_n == 0, "R1 iso_n", iso_n, 0);
        chk(psw_en == 0, "R1 psw_en", psw_en, 0);
        chk(dom_rst == 1, "R1 dom_rst", dom_rst, 1);
        chk(unit_avail == 0, "R1 unit_avail", unit_avail, 0);
        chk(pg_timeout_err == 0, "R1 err", pg_timeout_err, 0);
    endtask

    task automatic t_up(input int h);
        int n = 0;
        rst_hold = HOLD_W'(h);
        pg_dly = 0; pg_ok = 1'b1;
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 300; i++) begin
            if (iso_n) break;
            if (psw_en) n++;
            @(negedge clk);
        end
        chk(n == h + 2, "R2 clamp release delay", n, h + 2);
        chk(dom_rst == 1 && unit_avail == 0, "R2 release cycle", {dom_rst, unit_avail}, 2);
        @(negedge clk);
        chk(dom_rst == 0 && unit_avail == 1, "R2 R11 on state", {dom_rst, unit_avail}, 1);
    endtask

    task automatic t_dn_run();
        core_in_reset = 1'b0; sw_unit_off = 1'b0;
        pulse(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk(unit_avail == 0, "R4 avail drops", unit_avail, 0);
        repeat (6) @(negedge clk);
        chk(iso_n == 1 && psw_en == 1, "R4 waits for ack", {iso_n, psw_en}, 3);
        sw_unit_off = 1'b1;
        @(negedge clk);
        chk(iso_n == 0 && psw_en == 1, "R4 clamp first", {iso_n, psw_en}, 1);
        @(negedge clk);
        chk(iso_n == 0 && psw_en == 0, "R4 switch off", {iso_n, psw_en}, 0);
        sw_unit_off = 1'b0;
    endtask

    task automatic t_dn_rst();
        bit got;
        pulse(1'b1, 1'b0);
        wait_avail(got);
        chk(got, "R5 reached on", got, 1);
        core_in_reset = 1'b1; sw_unit_off = 1'b0;
        pulse(1'b0, 1'b1);
        @(negedge clk);
        chk(iso_n == 0 && psw_en == 1, "R5 clamp without ack", {iso_n, psw_en}, 1);
        @(negedge clk);
        chk(psw_en == 0, "R5 switch off", psw_en, 0);
        core_in_reset = 1'b0;
    endtask

    task automatic t_cold();
        int on_cnt = 0;
        bit got;
        cold_por = 1'b1;
        pulse(1'b1, 1'b0);
        repeat (20) begin
            @(negedge clk);
            if (psw_en) on_cnt++;
        end
        chk(on_cnt == 0, "R6 off during cold reset", on_cnt, 0);
        cold_por = 1'b0;
        wait_avail(got);
        chk(got, "R6 held request honoured", got, 1);
        cold_por = 1'b1;
        repeat (2) @(negedge clk);
        chk(iso_n == 0 && psw_en == 0, "R6 cold forces down", {iso_n, psw_en}, 0);
        on_cnt = 0;
        repeat (10) begin
            @(negedge clk);
            if (psw_en) on_cnt++;
        end
        chk(on_cnt == 0, "R6 stays off", on_cnt, 0);
        cold_por = 1'b0;
        wait_avail(got);
        chk(got, "R6 back on after cold", got, 1);
        core_in_reset = 1'b1;
        pulse(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        core_in_reset = 1'b0;
        chk(psw_en == 0, "R6 returned off", psw_en, 0);
    endtask

    task automatic t_pending();
        bit saw = 1'b0;
        pg_dly = 4'd6;
        sw_unit_off = 1'b1;
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (unit_avail) saw = 1'b1;
        end
        chk(saw, "R7 up completes before down", saw, 1);
        chk(psw_en == 0 && iso_n == 0, "R7 ends off", {psw_en, iso_n}, 0);
        sw_unit_off = 1'b0;
        pg_dly = 4'd0;
    endtask

    task automatic t_both();
        int on_cnt = 0;
        pulse(1'b1, 1'b1);
        repeat (10) begin
            @(negedge clk);
            if (psw_en) on_cnt++;
        end
        chk(on_cnt == 0, "R8 down wins", on_cnt, 0);
    endtask

    task automatic t_timeout();
        int on_cnt = 0, iso_bad = 0;
        bit got;
        pg_ok = 1'b0;
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 40; i++) begin
            if (psw_en) on_cnt++;
            if (iso_n) iso_bad++;
            @(negedge clk);
        end
        chk(on_cnt == PG_TO, "R10 switch window", on_cnt, PG_TO);
        chk(iso_bad == 0, "R10 clamp held", iso_bad, 0);
        chk(pg_timeout_err == 1, "R10 error raised", pg_timeout_err, 1);
        pg_ok = 1'b1;
        pulse(1'b1, 1'b0);
        wait_avail(got);
        chk(got, "R10 retry succeeds", got, 1);
        chk(pg_timeout_err == 1, "R10 error sticky", pg_timeout_err, 1);
        do_reset();
        chk(pg_timeout_err == 0, "R10 R1 reset clears error", pg_timeout_err, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_up(0);
        t_dn_run();
        t_up(5);
        t_dn_run();
        t_dn_rst();
        t_cold();
        t_pending();
        t_both();
        t_timeout();
        chk(viol_edge == 0, "R9 clamp and switch edges apart", viol_edge, 0);
        chk(viol_iso == 0, "R3 clamp released without power", viol_iso, 0);
        chk(viol_avail == 0, "R11 avail outside on", viol_avail, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule